// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache that sits between a processor load/store port and a slower block memory. Every line lives in one of two ways of the set picked by its block number. The two tags of that set are compared side by side, so a hit is answered without touching memory. Writes stay in the cache and mark the line dirty. Memory sees a modified line only when that line is evicted.

On a miss the controller picks a victim. An empty way is taken first. If both ways are full, the way not touched most recently is taken. A dirty victim is sent to memory in full before the missing block is requested. The refilled line is then installed, and the pending access completes against it, so a write miss merges its word into the freshly fetched block. The processor side uses a simple accept/response handshake. The memory side has one channel for block reads and one for block writes, and each request is held until memory pulses its done input.

Top module: `wbc_cache`

## Requirements
- R1: After reset every line is invalid and clean, every set's replacement pointer selects way 0, `req_ready` is 1, and `resp_valid`, `mem_rd_valid` and `mem_wr_valid` are 0.
- R2: The set index is the block number (word address divided by `WORDS`) modulo `SETS`, and both ways of that set are compared at once. A hit issues no memory request and returns the addressed word.
- R3: On a miss, a set that still has an invalid way fills that way (the lowest-numbered one first), so lines already present in the set are kept.
- R4: With both ways valid, a miss replaces the way not most recently hit or refilled. With 2 sets and 4 words per block, the block sequence 0, 8, 0, 6, 8 gives miss, miss, hit, miss, miss.
- R5: A write hit updates only the cached word and marks the line dirty. No memory write occurs, and the response data equals the written word.
- R6: When the victim is valid and dirty, its whole line is written to its own block address first. The refill read is issued only after that write completes.
- R7: A clean or invalid victim is never written to memory.
- R8: A write miss fetches the block, then merges the written word into it. Later reads return the new word at that offset and the memory contents at the other offsets. Memory itself keeps its old value.
- R9: `req_ready` is high only while idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. For a hit, `resp_valid` is a one-cycle pulse in the second cycle after acceptance; for a miss it comes later. `req_ready` stays low until after the pulse.
- R10: Memory requests are held with a stable block address until their done pulse, and a block read and a block write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Controller idle and able to accept |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Loaded word, or the stored word for a store |
| mem_rd_valid | output | 1 | Block read request |
| mem_rd_blk | output | ADDR_W-log2(WORDS) | Block number to read |
| mem_rd_done | input | 1 | Read data present this cycle |
| mem_rd_line | input | WORDS*DATA_W | Returned block, word 0 in the low bits |
| mem_wr_valid | output | 1 | Block write request |
| mem_wr_blk | output | ADDR_W-log2(WORDS) | Block number to write |
| mem_wr_line | output | WORDS*DATA_W | Block to write, word 0 in the low bits |
| mem_wr_done | input | 1 | Write accepted this cycle |

## Verification
The bench replays the five-block sequence into one set and counts block reads per access. A design that ignored empty ways or kept its recency pointer wrong would report a hit where a miss is due, or a miss where a hit is due. It then evicts a modified line and checks the address and data that reach memory. A controller that refilled before writing back, or that dropped the dirty flag on a write hit, would leave stale memory or request a read over a pending write. Clean evictions and write hits are checked for the absence of memory writes, which catches a write-through leak. A store that misses is read back at both its own offset and a neighbouring offset, which exposes a merge that clobbers the fetched block or one that skips the fetch.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COMPARE = 3'd1,
        ST_WRBACK  = 3'd2,
        ST_REFILL  = 3'd3,
        ST_RESPOND = 3'd4
    } wbc_state_e;
endpackage

// File: rtl/wbc_way_bank.sv
module wbc_way_bank #(
    parameter int SETS   = 2,
    parameter int TAG_W  = 7,
    parameter int LINE_W = 128,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line
);
    typedef struct packed {
        logic [SETS-1:0]              valid;
        logic [SETS-1:0]              dirty;
        logic [SETS-1:0][TAG_W-1:0]   tag;
        logic [SETS-1:0][LINE_W-1:0]  line;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            bank_d.valid[wr_idx] = wr_valid;
            bank_d.dirty[wr_idx] = wr_dirty;
            bank_d.tag[wr_idx]   = wr_tag;
            bank_d.line[wr_idx]  = wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rd_valid = bank_q.valid[rd_idx];
    assign rd_dirty = bank_q.dirty[rd_idx];
    assign rd_tag   = bank_q.tag[rd_idx];
    assign rd_line  = bank_q.line[rd_idx];
endmodule

// File: rtl/wbc_tag_match.sv
module wbc_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 7,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           lookup_tag,
    output logic                       hit_any,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == lookup_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit_any = |hit_vec;
endmodule

// File: rtl/wbc_victim_pick.sv
module wbc_victim_pick #(
    parameter int WAYS = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAY_W-1:0] lru_way,
    output logic [WAY_W-1:0] victim
);
    always_comb begin
        victim = lru_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int SETS   = 2,
    localparam int WAYS   = 2,
    localparam int WAY_W  = 1,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int BLK_W  = ADDR_W - OFF_W,
    localparam int TAG_W  = BLK_W - IDX_W,
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_rd_valid,
    output logic [BLK_W-1:0]  mem_rd_blk,
    input  logic              mem_rd_done,
    input  logic [LINE_W-1:0] mem_rd_line,
    output logic              mem_wr_valid,
    output logic [BLK_W-1:0]  mem_wr_blk,
    output logic [LINE_W-1:0] mem_wr_line,
    input  logic              mem_wr_done
);
    typedef struct packed {
        wbc_state_e        state;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic [SETS-1:0]   lru;
        logic [WAY_W-1:0]  victim;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // address fields of the latched request
    logic [OFF_W-1:0] cur_off;
    logic [IDX_W-1:0] cur_idx;
    logic [TAG_W-1:0] cur_tag;
    assign cur_off = ctl_q.addr[OFF_W-1:0];
    assign cur_idx = ctl_q.addr[OFF_W +: IDX_W];
    assign cur_tag = ctl_q.addr[ADDR_W-1 -: TAG_W];

    // per-way storage
    logic [WAYS-1:0]             way_valid;
    logic [WAYS-1:0]             way_dirty;
    logic [WAYS-1:0][TAG_W-1:0]  way_tag;
    logic [WAYS-1:0][LINE_W-1:0] way_line;

    logic [WAYS-1:0]   bank_we;
    logic              bank_wr_valid;
    logic              bank_wr_dirty;
    logic [LINE_W-1:0] bank_wr_line;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        wbc_way_bank #(
            .SETS   (SETS),
            .TAG_W  (TAG_W),
            .LINE_W (LINE_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (cur_idx),
            .wr_en    (bank_we[w]),
            .wr_idx   (cur_idx),
            .wr_valid (bank_wr_valid),
            .wr_dirty (bank_wr_dirty),
            .wr_tag   (cur_tag),
            .wr_line  (bank_wr_line),
            .rd_valid (way_valid[w]),
            .rd_dirty (way_dirty[w]),
            .rd_tag   (way_tag[w]),
            .rd_line  (way_line[w])
        );
    end

    logic             hit_any;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] pick_way;

    wbc_tag_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_match (
        .way_valid  (way_valid),
        .way_tag    (way_tag),
        .lookup_tag (cur_tag),
        .hit_any    (hit_any),
        .hit_way    (hit_way)
    );

    wbc_victim_pick #(
        .WAYS (WAYS)
    ) u_victim (
        .way_valid (way_valid),
        .lru_way   (ctl_q.lru[cur_idx]),
        .victim    (pick_way)
    );

    logic [LINE_W-1:0] hit_line;
    logic [LINE_W-1:0] merged_line;

    always_comb begin
        hit_line    = way_line[hit_way];
        merged_line = hit_line;
        merged_line[cur_off*DATA_W +: DATA_W] = ctl_q.wdata;
    end

    always_comb begin
        ctl_d         = ctl_q;
        bank_we       = '0;
        bank_wr_valid = 1'b0;
        bank_wr_dirty = 1'b0;
        bank_wr_line  = '0;
        req_ready     = 1'b0;
        resp_valid    = 1'b0;
        mem_rd_valid  = 1'b0;
        mem_rd_blk    = {cur_tag, cur_idx};
        mem_wr_valid  = 1'b0;
        mem_wr_blk    = {way_tag[ctl_q.victim], cur_idx};
        mem_wr_line   = way_line[ctl_q.victim];

        case (ctl_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    ctl_d.write = req_write;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.state = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                if (hit_any) begin
                    if (ctl_q.write) begin
                        bank_we[hit_way] = 1'b1;
                        bank_wr_valid    = 1'b1;
                        bank_wr_dirty    = 1'b1;
                        bank_wr_line     = merged_line;
                        ctl_d.rdata      = ctl_q.wdata;
                    end else begin
                        ctl_d.rdata = hit_line[cur_off*DATA_W +: DATA_W];
                    end
                    ctl_d.lru[cur_idx] = ~hit_way;
                    ctl_d.state        = ST_RESPOND;
                end else begin
                    ctl_d.victim = pick_way;
                    if (way_valid[pick_way] && way_dirty[pick_way])
                        ctl_d.state = ST_WRBACK;
                    else
                        ctl_d.state = ST_REFILL;
                end
            end
            ST_WRBACK: begin
                mem_wr_valid = 1'b1;
                if (mem_wr_done) ctl_d.state = ST_REFILL;
            end
            ST_REFILL: begin
                mem_rd_valid = 1'b1;
                if (mem_rd_done) begin
                    bank_we[ctl_q.victim] = 1'b1;
                    bank_wr_valid         = 1'b1;
                    bank_wr_dirty         = 1'b0;
                    bank_wr_line          = mem_rd_line;
                    ctl_d.lru[cur_idx]    = ~ctl_q.victim;
                    ctl_d.state           = ST_COMPARE;
                end
            end
            ST_RESPOND: begin
                resp_valid  = 1'b1;
                ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign resp_rdata = ctl_q.rdata;
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
    parameter int ADDR_W = 10,
    parameter int WORDS  = 4,
    localparam int BLK_W = ADDR_W - $clog2(WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             mem_rd_valid,
    input logic [BLK_W-1:0] mem_rd_blk,
    input logic             mem_rd_done,
    input logic             mem_wr_valid,
    input logic [BLK_W-1:0] mem_wr_blk,
    input logic             mem_wr_done
);
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_valid && mem_wr_valid));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_done |=> mem_rd_valid && $stable(mem_rd_blk));

    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_done |=> mem_wr_valid && $stable(mem_wr_blk));

    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && mem_wr_done |=> mem_rd_valid);

    p_resp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid || mem_rd_valid || mem_wr_valid) |-> !req_ready);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !mem_rd_valid && !mem_wr_valid && !req_ready);
endmodule

bind wbc_cache wbc_cache_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (.*);

// File: tb/wbc_cache_test.sv
module wbc_cache_test;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int WORDS  = 4;
    localparam int SETS   = 2;
    localparam int BLK_W  = ADDR_W - 2;
    localparam int LINE_W = WORDS * DATA_W;
    localparam int NWORD  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, resp_valid;
    logic [DATA_W-1:0] resp_rdata;
    logic mem_rd_valid, mem_wr_valid;
    logic [BLK_W-1:0] mem_rd_blk, mem_wr_blk;
    logic mem_rd_done = 1'b0, mem_wr_done = 1'b0;
    logic [LINE_W-1:0] mem_rd_line = '0;
    logic [LINE_W-1:0] mem_wr_line;

    always #2 clk = ~clk;

    wbc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .SETS(SETS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_blk(mem_rd_blk), .mem_rd_done(mem_rd_done),
        .mem_rd_line(mem_rd_line), .mem_wr_valid(mem_wr_valid), .mem_wr_blk(mem_wr_blk),
        .mem_wr_line(mem_wr_line), .mem_wr_done(mem_wr_done));

    logic [DATA_W-1:0] mem [NWORD];   // backing store
    logic [DATA_W-1:0] gold [NWORD];  // processor-visible contents
    int total = 0, bad = 0;
    int rd_cnt = 0, wr_cnt = 0, last_wr_blk = -1;
    bit finished = 1'b0;

    function automatic logic [DATA_W-1:0] init_word(int i);
        return (32'(i) * 32'h0001_0003) ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder: done after two request cycles
    initial begin
        int rd_wait = 0, wr_wait = 0;
        forever begin
            @(negedge clk);
            mem_rd_done = 1'b0;
            mem_wr_done = 1'b0;
            if (mem_rd_valid) begin
                rd_wait++;
                if (rd_wait == 2) begin
                    for (int k = 0; k < WORDS; k++)
                        mem_rd_line[k*DATA_W +: DATA_W] = mem[int'(mem_rd_blk)*WORDS + k];
                    mem_rd_done = 1'b1;
                    rd_cnt++;
                    rd_wait = 0;
                end
            end else rd_wait = 0;
            if (mem_wr_valid) begin
                wr_wait++;
                if (wr_wait == 2) begin
                    for (int k = 0; k < WORDS; k++)
                        mem[int'(mem_wr_blk)*WORDS + k] = mem_wr_line[k*DATA_W +: DATA_W];
                    mem_wr_done = 1'b1;
                    wr_cnt++;
                    last_wr_blk = int'(mem_wr_blk);
                    wr_wait = 0;
                end
            end else wr_wait = 0;
        end
    end

    task automatic access(input bit wr, input int a, input logic [DATA_W-1:0] d,
                          output logic [DATA_W-1:0] q, output int lat);
        int busy_ready = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(a); req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid) begin
            if (req_ready) busy_ready++;
            @(negedge clk);
            lat++;
        end
        q = resp_rdata;
        if (wr) gold[a] = d;
        total++;
        if (busy_ready != 0) begin
            bad++;
            $display("FAIL R9 ready high while busy actual=%0d expected=0", busy_ready);
        end
    endtask

    // read a block word, check data and whether it missed
    task automatic rd_expect(string req, int blk, int off, bit miss);
        logic [DATA_W-1:0] q;
        int lat, r0;
        r0 = rd_cnt;
        access(1'b0, blk*WORDS + off, '0, q, lat);
        chk(req, q, gold[blk*WORDS + off]);
        chk(req, 32'(rd_cnt - r0), miss ? 32'd1 : 32'd0);
        if (!miss) chk({req, " hit latency R9"}, 32'(lat), 32'd2);
    endtask

    task automatic t_reset;
        chk("R1 ready", {31'b0, req_ready}, 32'd1);
        chk("R1 resp", {31'b0, resp_valid}, 32'd0);
        chk("R1 memrd", {31'b0, mem_rd_valid}, 32'd0);
        chk("R1 memwr", {31'b0, mem_wr_valid}, 32'd0);
    endtask

    task automatic t_sequence;
        int w0 = wr_cnt;
        rd_expect("R3 blk0", 0, 0, 1'b1);
        rd_expect("R3 blk8", 8, 1, 1'b1);
        rd_expect("R4 blk0", 0, 2, 1'b0);
        rd_expect("R4 blk6", 6, 3, 1'b1);
        rd_expect("R4 blk8", 8, 0, 1'b1);
        chk("R7 clean evictions", 32'(wr_cnt - w0), 32'd0);
    endtask

    task automatic t_sets;
        rd_expect("R2 blk3 set1", 3, 1, 1'b1);
        rd_expect("R2 blk6 kept", 6, 2, 1'b0);
        rd_expect("R2 blk8 kept", 8, 3, 1'b0);
        rd_expect("R2 blk3 hit", 3, 0, 1'b0);
    endtask

    task automatic t_write_hit;
        logic [DATA_W-1:0] q;
        int lat, r0 = rd_cnt, w0 = wr_cnt;
        access(1'b1, 8*WORDS + 1, 32'hDEAD_BEEF, q, lat);
        chk("R5 resp data", q, 32'hDEAD_BEEF);
        chk("R5 latency", 32'(lat), 32'd2);
        chk("R5 no mem write", 32'(wr_cnt - w0), 32'd0);
        chk("R5 no mem read", 32'(rd_cnt - r0), 32'd0);
        chk("R5 memory stale", mem[8*WORDS + 1], init_word(8*WORDS + 1));
        rd_expect("R5 readback", 8, 1, 1'b0);
    endtask

    task automatic t_writeback;
        int w0;
        rd_expect("R6 touch blk6", 6, 0, 1'b0);
        rd_expect("R6 touch blk8", 8, 1, 1'b0);
        w0 = wr_cnt;
        rd_expect("R7 blk4 evicts clean 6", 4, 0, 1'b1);
        chk("R7 no write", 32'(wr_cnt - w0), 32'd0);
        rd_expect("R6 blk2 evicts dirty 8", 2, 2, 1'b1);
        chk("R6 one write", 32'(wr_cnt - w0), 32'd1);
        chk("R6 write block", 32'(last_wr_blk), 32'd8);
        chk("R6 written word", mem[8*WORDS + 1], 32'hDEAD_BEEF);
        chk("R6 other word", mem[8*WORDS + 2], init_word(8*WORDS + 2));
        rd_expect("R6 blk8 refetch", 8, 1, 1'b1);
    endtask

    task automatic t_write_miss;
        logic [DATA_W-1:0] q;
        int lat, r0 = rd_cnt;
        access(1'b1, 13*WORDS + 3, 32'h1234_5678, q, lat);
        chk("R8 fetched", 32'(rd_cnt - r0), 32'd1);
        chk("R8 resp data", q, 32'h1234_5678);
        chk("R8 slower than hit", {31'b0, lat > 2}, 32'd1);
        rd_expect("R8 merged word", 13, 3, 1'b0);
        rd_expect("R8 fetched word", 13, 0, 1'b0);
        chk("R8 memory unchanged", mem[13*WORDS + 3], init_word(13*WORDS + 3));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NWORD; i++) begin
            mem[i]  = init_word(i);
            gold[i] = init_word(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sequence();
        t_sets();
        t_write_hit();
        t_writeback();
        t_write_miss();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule